// File: doc/BRIEF.md
# State-Retention Power-Gating Sequencer

This block sequences a processor power domain into and out of a state-retention power-down. When wake-up detection is enabled, the deep-sleep indication is high and no debugger is attached, it first asks the processor to hold off execution by pulling the sleep-hold request low. Once the processor acknowledges, the sequencer steps through a fixed order: it stops the domain clock, isolates the domain outputs, puts the retention cells into retain mode, and finally removes power.

A wake-up request reverses the steps. The sequencer turns power back on and waits for the power-up-ready status. It then restores the retention cells, removes isolation and restarts the clock. The sleep hold is released only after all of that, so program execution resumes last. A build-time option lets an early wake-up, one that arrives before power is removed, cancel the entry. The steps already taken are then undone in reverse order. Every step is held for a minimum number of cycles before the next control output changes.

The states are IDLE, HOLD (sleep-hold request out, waiting for acknowledge), GATE, ISO, RET, OFF, PWRUP, UNRET, UNISO and CLKON. The transitions are:

- IDLE to HOLD: on the start condition.
- HOLD to GATE: on acknowledge after the dwell.
- HOLD to IDLE: when deep sleep drops or a debugger attaches.
- GATE to ISO to RET to OFF: each after its dwell.
- OFF to PWRUP: on wake-up after the dwell.
- PWRUP to UNRET: on power ready after the dwell.
- UNRET to UNISO to CLKON to IDLE: each after its dwell.
- Early abort: GATE goes to CLKON, ISO goes to UNISO and RET goes to UNRET.

Top module: `srpg_sequencer`

## Requirements
- R1: From IDLE, hold_req_n goes low one cycle after wake_en and deep_sleep are both high while dbg_attached is low. Otherwise it stays high.
- R2: clk_en drops only after hold_ack_n has been sampled low. While the acknowledge is absent, the sequencer stays in HOLD with clk_en, iso_n and ret_n at 1 and pwr_off at 0.
- R3: If deep_sleep falls while the sequencer is still waiting for the acknowledge, hold_req_n returns high on the next cycle and no other control output has changed.
- R4: Entry order is clk_en low, then iso_n low, then ret_n low, then pwr_off high. Each step changes exactly one output.
- R5: pwr_off stays high until wakeup is seen. After pwr_off falls, ret_n stays low for as long as pwr_ready is low.
- R6: Exit order is pwr_off low, ret_n high, iso_n high, clk_en high, and hold_req_n high last. When hold_req_n rises, all other controls are already at their run values.
- R7: With ALLOW_ABORT set, wakeup during GATE, ISO or RET moves the sequencer on the next cycle to the exit step that undoes the newest entry step. pwr_off never rises in that case.
- R8: While dbg_attached is high, the sequencer does not leave IDLE. A debugger attaching during HOLD returns the sequencer to IDLE.
- R9: Apart from an early abort, every control step lasts at least HOLD_CYCLES cycles before the next of clk_en, iso_n, ret_n or pwr_off changes.
- R10: After reset the outputs are hold_req_n=1, clk_en=1, iso_n=1, ret_n=1, pwr_off=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_en | input | 1 | Wake-up detection is enabled |
| deep_sleep | input | 1 | Processor reports deep sleep |
| dbg_attached | input | 1 | Debugger attached; blocks power-down |
| hold_ack_n | input | 1 | Sleep-hold acknowledge, active low |
| wakeup | input | 1 | Wake-up request from the detector |
| pwr_ready | input | 1 | Domain supply is up and stable |
| hold_req_n | output | 1 | Sleep-hold request, active low |
| clk_en | output | 1 | Domain clock enable |
| iso_n | output | 1 | Domain isolation, active low |
| ret_n | output | 1 | Retention control, active low |
| pwr_off | output | 1 | Power switch off request |

## Verification
The hardest situation to reach from the ports is an early wake-up that lands in the narrow window between isolation and power removal. Only a wake-up there makes the sequencer unwind from the middle of the entry order rather than the end. The bench drives the acknowledge so that the sequencer reaches the isolate step, then raises wakeup on the cycle it arrives. It then checks that the partial sequence unwinds back to IDLE and that power is never removed. A missing acknowledge followed by deep sleep dropping is provoked in the same cycle-counted way.

// File: rtl/srpg_pkg.sv
package srpg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HOLD,
        ST_GATE,
        ST_ISO,
        ST_RET,
        ST_OFF,
        ST_PWRUP,
        ST_UNRET,
        ST_UNISO,
        ST_CLKON
    } srpg_state_e;

    typedef struct packed {
        logic hold_req_n;
        logic clk_en;
        logic iso_n;
        logic ret_n;
        logic pwr_off;
    } srpg_ctl_t;

endpackage

// File: rtl/srpg_dwell_timer.sv
module srpg_dwell_timer #(
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'((HOLD_CYCLES > 0) ? HOLD_CYCLES - 1 : 0);

    logic [CW-1:0] cnt_q;

    assign done = (cnt_q >= LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/srpg_fsm.sv
module srpg_fsm
    import srpg_pkg::*;
#(
    parameter bit ALLOW_ABORT = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wake_en,
    input  logic      deep_sleep,
    input  logic      dbg_attached,
    input  logic      hold_ack_n,
    input  logic      wakeup,
    input  logic      pwr_ready,
    input  logic      step_done,
    output logic      restart,
    output srpg_ctl_t ctl
);
    srpg_state_e state_q, state_d;
    logic        abort;

    assign abort   = ALLOW_ABORT && wakeup;
    assign restart = (state_d != state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (wake_en && deep_sleep && !dbg_attached) state_d = ST_HOLD;
            ST_HOLD:
                if (!deep_sleep || dbg_attached)            state_d = ST_IDLE;
                else if (!hold_ack_n && step_done)          state_d = ST_GATE;
            ST_GATE:
                if (abort)                                  state_d = ST_CLKON;
                else if (step_done)                         state_d = ST_ISO;
            ST_ISO:
                if (abort)                                  state_d = ST_UNISO;
                else if (step_done)                         state_d = ST_RET;
            ST_RET:
                if (abort)                                  state_d = ST_UNRET;
                else if (step_done)                         state_d = ST_OFF;
            ST_OFF:
                if (wakeup && step_done)                    state_d = ST_PWRUP;
            ST_PWRUP:
                if (pwr_ready && step_done)                 state_d = ST_UNRET;
            ST_UNRET:
                if (step_done)                              state_d = ST_UNISO;
            ST_UNISO:
                if (step_done)                              state_d = ST_CLKON;
            ST_CLKON:
                if (step_done)                              state_d = ST_IDLE;
            default:                                        state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl = '{hold_req_n: 1'b0, clk_en: 1'b0, iso_n: 1'b0, ret_n: 1'b0, pwr_off: 1'b0};
        unique case (state_q)
            ST_IDLE:  ctl = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
            ST_HOLD:  ctl = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
            ST_GATE:  ctl = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
            ST_ISO:   ctl = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
            ST_RET:   ctl = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
            ST_OFF:   ctl = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
            ST_PWRUP: ctl = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
            ST_UNRET: ctl = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
            ST_UNISO: ctl = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
            ST_CLKON: ctl = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
            default:  ctl = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
        endcase
    end
endmodule

// File: rtl/srpg_sequencer.sv
module srpg_sequencer
    import srpg_pkg::*;
#(
    parameter int HOLD_CYCLES = 4,
    parameter bit ALLOW_ABORT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_en,
    input  logic deep_sleep,
    input  logic dbg_attached,
    input  logic hold_ack_n,
    input  logic wakeup,
    input  logic pwr_ready,
    output logic hold_req_n,
    output logic clk_en,
    output logic iso_n,
    output logic ret_n,
    output logic pwr_off
);
    logic      restart;
    logic      step_done;
    srpg_ctl_t ctl;

    srpg_dwell_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .done    (step_done)
    );

    srpg_fsm #(
        .ALLOW_ABORT(ALLOW_ABORT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wake_en      (wake_en),
        .deep_sleep   (deep_sleep),
        .dbg_attached (dbg_attached),
        .hold_ack_n   (hold_ack_n),
        .wakeup       (wakeup),
        .pwr_ready    (pwr_ready),
        .step_done    (step_done),
        .restart      (restart),
        .ctl          (ctl)
    );

    assign hold_req_n = ctl.hold_req_n;
    assign clk_en     = ctl.clk_en;
    assign iso_n      = ctl.iso_n;
    assign ret_n      = ctl.ret_n;
    assign pwr_off    = ctl.pwr_off;
endmodule

// File: rtl/srpg_sequencer_chk.sv
module srpg_sequencer_chk #(
    parameter int HOLD_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic wake_en,
    input logic deep_sleep,
    input logic dbg_attached,
    input logic hold_ack_n,
    input logic wakeup,
    input logic pwr_ready,
    input logic hold_req_n,
    input logic clk_en,
    input logic iso_n,
    input logic ret_n,
    input logic pwr_off
);
    logic [3:0] step_now, step_prev;
    int         stable_cnt;

    assign step_now = {clk_en, iso_n, ret_n, pwr_off};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_prev  <= 4'b1110;
            stable_cnt <= HOLD_CYCLES;
        end else begin
            step_prev <= step_now;
            if (step_now != step_prev) stable_cnt <= 0;
            else if (stable_cnt < HOLD_CYCLES) stable_cnt <= stable_cnt + 1;
        end
    end

    p_entry_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_req_n) |-> $past(wake_en && deep_sleep && !dbg_attached));

    p_gate_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> $past(!hold_ack_n) && !hold_req_n);

    p_iso_after_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_n) |-> !clk_en && ret_n && !pwr_off);

    p_ret_after_iso_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ret_n) |-> !iso_n && !clk_en && !pwr_off);

    p_off_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_off) |-> !ret_n && !iso_n && !clk_en);

    p_wake_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_off) |-> $past(wakeup));

    p_ready_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_n) && !iso_n |-> $past(pwr_ready) || !$past(pwr_off, 2));

    p_release_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req_n) |-> clk_en && iso_n && ret_n && !pwr_off);

    p_dbg_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_attached && hold_req_n |=> hold_req_n);

    p_min_dwell_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_now != step_prev) && !$past(wakeup) |-> stable_cnt >= HOLD_CYCLES - 1);
endmodule

bind srpg_sequencer srpg_sequencer_chk #(
    .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake_en      (wake_en),
    .deep_sleep   (deep_sleep),
    .dbg_attached (dbg_attached),
    .hold_ack_n   (hold_ack_n),
    .wakeup       (wakeup),
    .pwr_ready    (pwr_ready),
    .hold_req_n   (hold_req_n),
    .clk_en       (clk_en),
    .iso_n        (iso_n),
    .ret_n        (ret_n),
    .pwr_off      (pwr_off)
);

// File: tb/srpg_sequencer_bench.sv
module srpg_sequencer_bench;
    localparam int HOLD = 2;
    localparam int NVEC = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake_en = 1'b0, deep_sleep = 1'b0, dbg_attached = 1'b0;
    logic hold_ack_n = 1'b1, wakeup = 1'b0, pwr_ready = 1'b0;
    logic hold_req_n, clk_en, iso_n, ret_n, pwr_off;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    srpg_sequencer #(
        .HOLD_CYCLES (HOLD),
        .ALLOW_ABORT (1'b1)
    ) u_srpg_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .wake_en      (wake_en),
        .deep_sleep   (deep_sleep),
        .dbg_attached (dbg_attached),
        .hold_ack_n   (hold_ack_n),
        .wakeup       (wakeup),
        .pwr_ready    (pwr_ready),
        .hold_req_n   (hold_req_n),
        .clk_en       (clk_en),
        .iso_n        (iso_n),
        .ret_n        (ret_n),
        .pwr_off      (pwr_off)
    );

    // {wake_en, deep_sleep, dbg_attached, hold_ack_n, wakeup, pwr_ready}, cycles,
    // expected {hold_req_n, clk_en, iso_n, ret_n, pwr_off}
    localparam logic [14:0] VEC [NVEC] = '{
        {6'b010100, 4'd2, 5'b11110},  // R1 no entry without wake_en
        {6'b100100, 4'd2, 5'b11110},  // R1 no entry without deep_sleep
        {6'b110100, 4'd1, 5'b01110},  // R1 HOLD
        {6'b110000, 4'd2, 5'b00110},  // R2 GATE after ack
        {6'b110000, 4'd2, 5'b00010},  // R4 ISO
        {6'b110000, 4'd2, 5'b00000},  // R4 RET
        {6'b110000, 4'd2, 5'b00001},  // R4 OFF
        {6'b110000, 4'd4, 5'b00001},  // R5 stays off
        {6'b110010, 4'd1, 5'b00000},  // R5 PWRUP
        {6'b000000, 4'd3, 5'b00000},  // R5 waits for pwr_ready
        {6'b000001, 4'd1, 5'b00010},  // R6 UNRET
        {6'b000001, 4'd2, 5'b00110},  // R6 UNISO
        {6'b000001, 4'd2, 5'b01110},  // R6 CLKON
        {6'b000001, 4'd2, 5'b11110}   // R6 release last, IDLE
    };

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {hold_req_n, clk_en, iso_n, ret_n, pwr_off};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] in);
        {wake_en, deep_sleep, dbg_attached, hold_ack_n, wakeup, pwr_ready} = in;
    endtask

    task automatic step(input logic [5:0] in, input int cyc, input string req, input logic [4:0] exp);
        drive(in);
        repeat (cyc) @(negedge clk);
        check(req, exp);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        drive(6'b000100);
        repeat (3) @(negedge clk);
        check("R10", 5'b11110);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", 5'b11110);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][14:9], int'(VEC[i][8:5]), $sformatf("R%0d table row %0d", 1, i), VEC[i][4:0]);
        end

        // R3: acknowledge never comes
        step(6'b110101, 1, "R3 hold", 5'b01110);
        step(6'b110101, 5, "R3 no power action", 5'b01110);
        step(6'b000101, 1, "R3 release", 5'b11110);

        // R8: debugger blocks entry
        step(6'b111001, 4, "R8 blocked", 5'b11110);
        step(6'b110001, 1, "R8 enter after detach", 5'b01110);
        step(6'b111001, 1, "R8 attach in HOLD", 5'b11110);
        step(6'b000101, 2, "R8 idle", 5'b11110);

        // R7: early wakeup at the isolate step
        step(6'b110101, 1, "R7 hold", 5'b01110);
        step(6'b110001, 2, "R7 gate", 5'b00110);
        step(6'b110001, 2, "R7 iso", 5'b00010);
        step(6'b110011, 1, "R7 abort to UNISO", 5'b00110);
        step(6'b000101, 1, "R9 UNISO dwell", 5'b00110);
        step(6'b000101, 1, "R7 CLKON", 5'b01110);
        step(6'b000101, 2, "R7 back to IDLE", 5'b11110);

        // R7: early wakeup at the gate step
        step(6'b110101, 1, "R7 hold", 5'b01110);
        step(6'b110001, 2, "R7 gate", 5'b00110);
        step(6'b110011, 1, "R7 abort to CLKON", 5'b01110);
        step(6'b000101, 2, "R7 idle, power never removed", 5'b11110);

        summary();
    end
endmodule